// File: doc/BRIEF.md
# Stride-Detecting Load Prefetcher

This block watches the stream of executed loads. Each load carries the program counter of the instruction and the data address it touched. The block keeps a small direct-mapped table indexed by low PC bits. For every load it learns the distance between consecutive addresses of that instruction and tracks how reliable that distance has been. Once an instruction has shown a repeating stride, the block asks for the address one stride beyond the current access, so a cache or prefetch buffer can fetch it ahead of use.

Each table entry holds the upper PC bits as a tag, the last address seen, a signed stride and a two-bit confidence state. The state is one of init, transient, steady or no-prediction.

Loads are observed through a valid-only input. They are never stalled, so the load side has no ready signal. Prefetch requests leave through a valid/ready output holding one slot. A request stays valid with a stable address until `pf_ready` is seen high at a clock edge. The one exception is a newer request produced while the slot is still pending: the newer request replaces the older one, which is dropped. Back-pressure therefore costs prefetches but never loads.

Top module: `stride_pf_top`

## Requirements
- R1: After reset `pf_valid` is low and every table entry is invalid, so the first load of any PC is a tag miss.
- R2: On a tag miss, the entry at index `ld_pc[IDX_W-1:0]` gets tag `ld_pc[PC_W-1:IDX_W]`, the load address, a stride of zero and the init state. No prefetch is produced.
- R3: On a hit, the prediction is correct when `ld_addr` equals the stored previous address plus the stored stride, modulo 2^ADDR_W. The previous address is then replaced by `ld_addr` whatever the outcome.
- R4: A correct prediction moves init or transient to steady, and keeps steady in steady. The stride is left unchanged.
- R5: An incorrect prediction moves init to transient, moves transient to no-prediction, and keeps no-prediction in no-prediction. Each of these replaces the stride with `ld_addr` minus the previous address.
- R6: An incorrect prediction in steady moves the entry to init and keeps the stored stride.
- R7: A correct prediction in no-prediction moves the entry to transient.
- R8: When a hit leaves its entry in steady, `pf_valid` is high in the cycle after the load edge, with `pf_addr` equal to `ld_addr` plus the stride, modulo 2^ADDR_W.
- R9: A pending request keeps `pf_valid` high and `pf_addr` stable until an edge with `pf_ready` high. That edge clears it unless a new request arrives at the same edge.
- R10: A new request at an edge where the slot is still pending replaces the pending address. Loads are accepted every cycle regardless of `pf_ready`.
- R11: Two PCs with the same low index bits but different tags evict each other. Each return of such a PC is treated as a miss.
- R12: Strides are signed, so descending address streams reach steady and produce prefetches below the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is observed this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Data address of the load |
| pf_valid | output | 1 | Prefetch request pending |
| pf_ready | input | 1 | Consumer accepts the pending request |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
The checker watches the output slot on every cycle. It confirms that a stalled request holds a stable address, that `pf_valid` only drops after an accept, that nothing appears without a load, and that a miss never issues. It also confirms that a failed prediction in steady keeps the stride. The full confidence walk across states, signed stride learning, and eviction between PCs that share an index can only be shown by the bench's scenarios. The bench compares every cycle against its own table model, which is driven by descending, ascending, zero and conflicting address streams.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2,
    ST_NOPRED = 2'd3
  } pf_state_e;
endpackage

// File: rtl/stride_pf_table.sv
module stride_pf_table
  import stride_pf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 28,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  tag,
  output logic              hit,
  output logic [ADDR_W-1:0] rd_prev,
  output logic [ADDR_W-1:0] rd_stride,
  output pf_state_e         rd_state,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_prev,
  input  logic [ADDR_W-1:0] wr_stride,
  input  pf_state_e         wr_state
);
  logic [ENTRIES-1:0] ent_vld;
  logic [TAG_W-1:0]   ent_tag    [ENTRIES];
  logic [ADDR_W-1:0]  ent_prev   [ENTRIES];
  logic [ADDR_W-1:0]  ent_stride [ENTRIES];
  pf_state_e          ent_state  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld[g] <= 1'b0;
      end else if (sel) begin
        ent_vld[g] <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (sel) begin
        ent_tag[g]    <= tag;
        ent_prev[g]   <= wr_prev;
        ent_stride[g] <= wr_stride;
        ent_state[g]  <= wr_state;
      end
    end
  end

  assign hit       = ent_vld[idx] && (ent_tag[idx] == tag);
  assign rd_prev   = ent_prev[idx];
  assign rd_stride = ent_stride[idx];
  assign rd_state  = ent_state[idx];
endmodule

// File: rtl/stride_pf_update.sv
module stride_pf_update
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              hit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] rd_prev,
  input  logic [ADDR_W-1:0] rd_stride,
  input  pf_state_e         rd_state,
  output logic              pred_ok,
  output logic [ADDR_W-1:0] nxt_stride,
  output pf_state_e         nxt_state,
  output logic              issue,
  output logic [ADDR_W-1:0] target
);
  logic [ADDR_W-1:0] guess;
  logic [ADDR_W-1:0] delta;

  assign guess   = rd_prev + rd_stride;
  assign delta   = addr - rd_prev;
  assign pred_ok = (addr == guess);

  always_comb begin
    nxt_stride = rd_stride;
    nxt_state  = rd_state;
    if (!hit) begin
      nxt_stride = '0;
      nxt_state  = ST_INIT;
    end else begin
      unique case (rd_state)
        ST_INIT: begin
          if (pred_ok) nxt_state = ST_STEADY;
          else begin
            nxt_state  = ST_TRANS;
            nxt_stride = delta;
          end
        end
        ST_TRANS: begin
          if (pred_ok) nxt_state = ST_STEADY;
          else begin
            nxt_state  = ST_NOPRED;
            nxt_stride = delta;
          end
        end
        ST_STEADY: begin
          if (!pred_ok) nxt_state = ST_INIT;
        end
        ST_NOPRED: begin
          if (pred_ok) nxt_state = ST_TRANS;
          else nxt_stride = delta;
        end
        default: nxt_state = ST_INIT;
      endcase
    end
  end

  assign issue  = hit && (nxt_state == ST_STEADY);
  assign target = addr + nxt_stride;
endmodule

// File: rtl/stride_pf_slot.sv
module stride_pf_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_vld,
  input  logic [ADDR_W-1:0] new_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (new_vld) begin
      pf_valid <= 1'b1;
      pf_addr  <= new_addr;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stride_pf_top.sv
module stride_pf_top
  import stride_pf_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              lk_hit;
  logic [ADDR_W-1:0] rd_prev;
  logic [ADDR_W-1:0] rd_stride;
  pf_state_e         rd_state;
  logic              pred_ok;
  logic [ADDR_W-1:0] nxt_stride;
  pf_state_e         nxt_state;
  logic              issue;
  logic [ADDR_W-1:0] target;
  logic              new_vld;

  assign lk_idx  = ld_pc[IDX_W-1:0];
  assign lk_tag  = ld_pc[PC_W-1:IDX_W];
  assign new_vld = ld_valid && issue;

  stride_pf_table #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .idx(lk_idx), .tag(lk_tag), .hit(lk_hit),
    .rd_prev(rd_prev), .rd_stride(rd_stride), .rd_state(rd_state),
    .wr_en(ld_valid), .wr_prev(ld_addr), .wr_stride(nxt_stride),
    .wr_state(nxt_state)
  );

  stride_pf_update #(.ADDR_W(ADDR_W)) u_update (
    .hit(lk_hit), .addr(ld_addr), .rd_prev(rd_prev), .rd_stride(rd_stride),
    .rd_state(rd_state), .pred_ok(pred_ok), .nxt_stride(nxt_stride),
    .nxt_state(nxt_state), .issue(issue), .target(target)
  );

  stride_pf_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .new_vld(new_vld), .new_addr(target),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );
endmodule

// File: rtl/stride_pf_chk.sv
module stride_pf_chk
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              lk_hit,
  input pf_state_e         rd_state,
  input logic              pred_ok,
  input logic [ADDR_W-1:0] rd_stride,
  input logic [ADDR_W-1:0] nxt_stride,
  input pf_state_e         nxt_state,
  input logic              new_vld
);
  // R9
  hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready && !ld_valid |=> pf_valid && $stable(pf_addr));

  // R9
  drop_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pf_valid) |-> $past(pf_ready));

  // R2
  miss_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !lk_hit |-> !new_vld);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid && !pf_valid |=> !pf_valid);

  // R8
  issue_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_vld |=> pf_valid);

  // R6
  steady_miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && lk_hit && rd_state == ST_STEADY && !pred_ok
      |-> nxt_stride == rd_stride && nxt_state == ST_INIT);
endmodule

bind stride_pf_top stride_pf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .pf_valid(pf_valid),
  .pf_ready(pf_ready), .pf_addr(pf_addr), .lk_hit(lk_hit),
  .rd_state(rd_state), .pred_ok(pred_ok), .rd_stride(rd_stride),
  .nxt_stride(nxt_stride), .nxt_state(nxt_state), .new_vld(new_vld)
);

// File: tb/stride_pf_top_tb.sv
`timescale 1ns/1ps
module stride_pf_top_tb;
  localparam int PC_W = 32, ADDR_W = 32, ENTRIES = 16;
  localparam int IDX_W = $clog2(ENTRIES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0, pf_ready = 1'b0;
  logic [PC_W-1:0] ld_pc = '0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic pf_valid;
  logic [ADDR_W-1:0] pf_addr;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  stride_pf_top #(.PC_W(PC_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
    .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr)
  );

  // reference table: 0 init, 1 transient, 2 steady, 3 no-prediction
  bit                m_vld    [ENTRIES];
  logic [PC_W-1:0]   m_tag    [ENTRIES];
  logic [ADDR_W-1:0] m_prev   [ENTRIES];
  logic [ADDR_W-1:0] m_stride [ENTRIES];
  int                m_state  [ENTRIES];
  bit                m_pv = 1'b0;
  logic [ADDR_W-1:0] m_pa = '0;

  task automatic check(bit ok, string tag, logic [ADDR_W-1:0] act,
                       logic [ADDR_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_load(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a,
                            output bit nv, output logic [ADDR_W-1:0] na,
                            output string tag);
    int i;
    logic [PC_W-1:0] tg;
    logic [ADDR_W-1:0] d;
    bit ok;
    i  = int'(pc[IDX_W-1:0]);
    tg = pc >> IDX_W;
    nv = 1'b0;
    na = '0;
    if (!m_vld[i] || m_tag[i] != tg) begin
      tag = m_vld[i] ? "R11" : "R2";
      m_vld[i] = 1'b1; m_tag[i] = tg; m_prev[i] = a;
      m_stride[i] = '0; m_state[i] = 0;
    end else begin
      ok = (a == m_prev[i] + m_stride[i]);   // R3
      d  = a - m_prev[i];
      if (ok) begin
        tag = (m_state[i] == 3) ? "R7" : (m_state[i] == 2) ? "R3/R8" : "R4";
        m_state[i] = (m_state[i] == 3) ? 1 : 2;
      end else if (m_state[i] == 2) begin
        tag = "R6";
        m_state[i] = 0;
      end else begin
        tag = d[ADDR_W-1] ? "R12" : "R5";
        m_stride[i] = d;
        m_state[i] = (m_state[i] == 0) ? 1 : 3;
      end
      m_prev[i] = a;
      nv = (m_state[i] == 2);
      na = a + m_stride[i];
    end
  endtask

  task automatic step(bit v, logic [PC_W-1:0] pc, logic [ADDR_W-1:0] a, bit rdy);
    bit nv;
    logic [ADDR_W-1:0] na;
    string tag;
    bit was_stuck;
    @(negedge clk);
    ld_valid = v; ld_pc = pc; ld_addr = a; pf_ready = rdy;
    @(posedge clk);
    #1;
    was_stuck = m_pv && !rdy;
    nv = 1'b0; na = '0; tag = "R9";
    if (v) model_load(pc, a, nv, na, tag);
    if (nv && was_stuck) tag = "R10";
    if (nv) begin m_pv = 1'b1; m_pa = na; end
    else if (m_pv && rdy) m_pv = 1'b0;
    check(pf_valid == m_pv, {tag, " valid"}, ADDR_W'(pf_valid), ADDR_W'(m_pv));
    if (m_pv) check(pf_addr == m_pa, {tag, " addr"}, pf_addr, m_pa);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [PC_W-1:0]   s_pc   [6];
  logic [ADDR_W-1:0] s_addr [6];
  logic [ADDR_W-1:0] s_str  [6];

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < ENTRIES; i++) m_vld[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: output idle after reset
    check(pf_valid == 1'b0, "R1 reset", ADDR_W'(pf_valid), '0);

    // ascending walk: miss, init->trans, trans->steady, steady
    step(1, 32'h100, 32'h1000, 1);
    step(1, 32'h100, 32'h1008, 1);
    step(1, 32'h100, 32'h1010, 1);
    step(1, 32'h100, 32'h1018, 1);
    step(0, 0, 0, 1);
    // steady break keeps stride, then re-lock (R6, R4)
    step(1, 32'h100, 32'h5000, 1);
    step(1, 32'h100, 32'h5008, 1);
    // descending stride (R12), stalled consumer (R9, R10)
    step(1, 32'h201, 32'h8000, 0);
    step(1, 32'h201, 32'h7FF0, 0);
    step(1, 32'h201, 32'h7FE0, 0);
    step(0, 0, 0, 0);
    step(1, 32'h201, 32'h7FD0, 0);
    step(0, 0, 0, 1);
    // transient -> no-prediction -> transient (R5, R7)
    step(1, 32'h302, 32'h100, 1);
    step(1, 32'h302, 32'h104, 1);
    step(1, 32'h302, 32'h200, 1);
    step(1, 32'h302, 32'h300, 1);
    step(1, 32'h302, 32'h400, 1);
    step(1, 32'h302, 32'h500, 1);
    // index conflict (R11)
    step(1, 32'h403, 32'h40, 1);
    step(1, 32'h413, 32'h80, 1);
    step(1, 32'h403, 32'h44, 1);

    s_pc[0] = 32'h1001; s_pc[1] = 32'h1002; s_pc[2] = 32'h1003;
    s_pc[3] = 32'h2003; s_pc[4] = 32'h1005; s_pc[5] = 32'h1006;
    s_str[0] = 32'd8;  s_str[1] = -32'sd16; s_str[2] = 32'd4;
    s_str[3] = 32'd64; s_str[4] = 32'd0;    s_str[5] = 32'd24;
    for (int i = 0; i < 6; i++) s_addr[i] = $urandom;
    for (int n = 0; n < 4000; n++) begin
      int k;
      bit v;
      k = int'($urandom_range(0, 5));
      v = ($urandom_range(0, 3) != 0);
      if (v) begin
        if ($urandom_range(0, 15) == 0) s_addr[k] = $urandom;
        else if ($urandom_range(0, 31) == 0) s_str[k] = s_str[k] + 32'd4;
        else s_addr[k] = s_addr[k] + s_str[k];
      end
      step(v, s_pc[k], s_addr[k], $urandom_range(0, 1) == 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule